// File: doc/BRIEF.md
# Branch-Outcome Trace Encoder

This block sits beside a processor core and turns its retirement strobes into a stream of short trace messages. Only information that cannot be recomputed from the program image leaves the block: the taken/not-taken outcome of each conditional branch, and the target address of each indirect jump or exception. Sequential flow and direct unconditional branches raise no strobe and therefore cost nothing in the trace.

Conditional-branch outcomes are packed into a history register. That register is flushed as a message when it fills, or just before a target message so that the order of events is kept. Messages wait in a small FIFO and leave through a valid/ready handshake. When the FIFO cannot take the messages that a cycle produces, those messages are discarded. A single overflow message, carrying the number of discarded event cycles, is then queued as soon as a slot frees.

Each message has a 2-bit kind, a 5-bit length and a 32-bit payload.

Top module: `trace_encoder`

## Requirements
- R1: After reset the FIFO is empty, `msg_valid` is low and the branch history is empty.
- R2: A history message has kind 2'b00. Its length field holds the number of outcomes it carries (1..HIST_W). Payload bit i is the outcome of the i-th branch in retirement order (1 = taken), and the unused upper bits are zero. A history message is emitted in the cycle the HIST_W-th outcome arrives (HIST_W = 16 by default).
- R3: Cycles with no strobe (sequential code, direct jumps) produce no message and leave the branch history unchanged.
- R4: An indirect-jump strobe first flushes any non-empty history as a history message. It then queues a message of kind 2'b01, length 0, with the payload taken from `ev_addr`.
- R5: An exception strobe behaves like R4 but with kind 2'b10. When both strobes are high in one cycle, only the exception message is produced.
- R6: A branch outcome that arrives in the same cycle as an indirect jump or exception is placed in the history before that history is flushed. The history message therefore precedes the target message.
- R7: If a cycle needs more messages than the FIFO has free slots, all of that cycle's messages are dropped and the history is cleared. From then on, every event is discarded until a slot is free. In that cycle one message of kind 2'b11, length 0, is queued. Its payload is the number of cycles with at least one strobe that were discarded, including the current cycle.
- R8: Messages leave in the order they were queued. While `msg_valid` is high and `msg_ready` is low, the head message is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | A conditional branch retired |
| br_taken | input | 1 | Outcome of that branch (1 = taken) |
| ind_valid | input | 1 | An indirect jump retired |
| exc_valid | input | 1 | An exception was taken |
| ev_addr | input | 32 | Target address for indirect jump or exception |
| msg_valid | output | 1 | Head message available |
| msg_ready | input | 1 | Sink accepts the head message |
| msg_type | output | 2 | Message kind |
| msg_len | output | 5 | Outcome count for history messages, else 0 |
| msg_payload | output | 32 | History bits, target address or drop count |

## Verification
Two functions often fall in the same cycle. A branch outcome can arrive together with a jump or exception, which forces a history flush and a target message in one cycle. The overflow message can be written in the same cycle as a fresh strobe, which must be counted rather than traced. The bench drives both cases on purpose: a branch with an indirect jump on the 16th outcome, exception and indirect strobes together, and a stalled sink that fills the FIFO while strobes continue. Random stimulus with a sink whose readiness varies repeats these collisions many times. A bench model of the FIFO occupancy predicts every message, including the exact drop count.

// File: rtl/trace_pkg.sv
package trace_pkg;
  localparam int PAYLOAD_W = 32;
  localparam int LEN_W     = 5;

  typedef enum logic [1:0] {
    MSG_HIST = 2'b00,
    MSG_IND  = 2'b01,
    MSG_EXC  = 2'b10,
    MSG_OVF  = 2'b11
  } msg_kind_e;

  typedef struct packed {
    msg_kind_e            kind;
    logic [LEN_W-1:0]     len;
    logic [PAYLOAD_W-1:0] data;
  } trace_msg_t;
endpackage

// File: rtl/trace_history.sv
module trace_history #(
  parameter int HIST_W = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        br_v,
  input  logic        br_t,
  input  logic        jump,
  input  logic        commit,
  input  logic        clr,
  output logic        flush,
  output logic [4:0]  flush_len,
  output logic [31:0] flush_bits
);
  localparam int LW = $clog2(HIST_W + 1);

  logic [LW-1:0]     len_q, len_nxt;
  logic [HIST_W-1:0] bits_q, bits_nxt;

  always_comb begin
    len_nxt    = len_q + LW'(br_v);
    bits_nxt   = bits_q | (HIST_W'(br_v & br_t) << len_q);
    flush      = (len_nxt == LW'(HIST_W)) || (jump && (len_nxt != '0));
    flush_len  = 5'(len_nxt);
    flush_bits = 32'(bits_nxt);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      len_q  <= '0;
      bits_q <= '0;
    end else if (commit) begin
      if (flush) begin
        len_q  <= '0;
        bits_q <= '0;
      end else begin
        len_q  <= len_nxt;
        bits_q <= bits_nxt;
      end
    end
  end
endmodule

// File: rtl/trace_fifo.sv
module trace_fifo
  import trace_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    wr_n,
  input  trace_msg_t    wr_a,
  input  trace_msg_t    wr_b,
  input  logic          pop,
  output trace_msg_t    head,
  output logic [CW-1:0] count
);
  trace_msg_t    mem [DEPTH];
  logic [AW-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (wr_n != 2'd0) mem[wp] <= wr_a;
    if (wr_n == 2'd2) mem[wp + AW'(1)] <= wr_b;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      wp    <= wp + AW'(wr_n);
      rp    <= rp + AW'(pop);
      count <= count + CW'(wr_n) - CW'(pop);
    end
  end

  assign head = mem[rp];
endmodule

// File: rtl/trace_encoder.sv
module trace_encoder
  import trace_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int HIST_W = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        br_valid,
  input  logic        br_taken,
  input  logic        ind_valid,
  input  logic        exc_valid,
  input  logic [31:0] ev_addr,
  output logic        msg_valid,
  input  logic        msg_ready,
  output logic [1:0]  msg_type,
  output logic [4:0]  msg_len,
  output logic [31:0] msg_payload
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          jump, ev, flush, drop_now, pend_q, pop;
  logic [4:0]    flush_len;
  logic [31:0]   flush_bits, dcnt_q, dcnt_inc;
  logic [1:0]    n_need, wr_n;
  logic [CW-1:0] fifo_cnt, free;
  trace_msg_t    wr_a, wr_b, head, hist_msg, tgt_msg;

  assign jump = ind_valid | exc_valid;
  assign ev   = br_valid | jump;

  trace_history #(.HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst(rst), .br_v(br_valid), .br_t(br_taken), .jump(jump),
    .commit(ev & ~drop_now), .clr(drop_now),
    .flush(flush), .flush_len(flush_len), .flush_bits(flush_bits)
  );

  always_comb begin
    free     = CW'(DEPTH) - fifo_cnt;
    n_need   = {1'b0, flush} + {1'b0, jump};
    dcnt_inc = (dcnt_q == '1) ? dcnt_q : dcnt_q + 32'(ev);
    hist_msg = '{kind: MSG_HIST, len: flush_len, data: flush_bits};
    tgt_msg  = '{kind: (exc_valid ? MSG_EXC : MSG_IND), len: '0, data: ev_addr};
    wr_n     = 2'd0;
    wr_a     = hist_msg;
    wr_b     = tgt_msg;
    drop_now = 1'b0;
    if (pend_q) begin
      drop_now = 1'b1;
      if (free != '0) begin
        wr_n = 2'd1;
        wr_a = '{kind: MSG_OVF, len: '0, data: dcnt_inc};
      end
    end else if (CW'(n_need) > free) begin
      drop_now = 1'b1;
    end else begin
      wr_n = n_need;
      wr_a = flush ? hist_msg : tgt_msg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      dcnt_q <= '0;
    end else if (pend_q) begin
      if (free != '0) begin
        pend_q <= 1'b0;
        dcnt_q <= '0;
      end else begin
        dcnt_q <= dcnt_inc;
      end
    end else if (CW'(n_need) > free) begin
      pend_q <= 1'b1;
      dcnt_q <= 32'd1;
    end
  end

  trace_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_n(wr_n), .wr_a(wr_a), .wr_b(wr_b),
    .pop(pop), .head(head), .count(fifo_cnt)
  );

  assign msg_valid   = (fifo_cnt != '0);
  assign pop         = msg_valid & msg_ready;
  assign msg_type    = head.kind;
  assign msg_len     = head.len;
  assign msg_payload = head.data;
endmodule

// File: rtl/trace_encoder_chk.sv
module trace_encoder_chk #(
  parameter int DEPTH  = 8,
  parameter int HIST_W = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          msg_valid,
  input logic          msg_ready,
  input logic [1:0]    msg_type,
  input logic [4:0]    msg_len,
  input logic [31:0]   msg_payload,
  input logic [CW-1:0] fifo_cnt
);
  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !msg_valid); // R1

  AST_HIST_LEN: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_type == 2'b00) |-> (msg_len != 5'd0 && 32'(msg_len) <= HIST_W)); // R2

  AST_TARGET_LEN: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && (msg_type == 2'b01 || msg_type == 2'b10)) |-> msg_len == 5'd0); // R4

  AST_OVF_COUNT: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_type == 2'b11) |-> (msg_payload != 32'd0 && msg_len == 5'd0)); // R7

  AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (rst)
    32'(fifo_cnt) <= DEPTH); // R7

  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_type) && $stable(msg_len)
                                   && $stable(msg_payload))); // R8
endmodule

bind trace_encoder trace_encoder_chk #(.DEPTH(DEPTH), .HIST_W(HIST_W)) u_chk (
  .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_type(msg_type), .msg_len(msg_len), .msg_payload(msg_payload),
  .fifo_cnt(fifo_cnt)
);

// File: tb/tb_trace_encoder.sv
module tb_trace_encoder;
  localparam int DEPTH = 8;
  localparam int HW    = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic br_valid = 0, br_taken = 0, ind_valid = 0, exc_valid = 0, msg_ready = 0;
  logic [31:0] ev_addr = '0;
  logic msg_valid;
  logic [1:0] msg_type;
  logic [4:0] msg_len;
  logic [31:0] msg_payload;

  always #4 clk = ~clk;

  trace_encoder #(.DEPTH(DEPTH), .HIST_W(HW)) dut (
    .clk(clk), .rst(rst), .br_valid(br_valid), .br_taken(br_taken),
    .ind_valid(ind_valid), .exc_valid(exc_valid), .ev_addr(ev_addr),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_type(msg_type),
    .msg_len(msg_len), .msg_payload(msg_payload)
  );

  typedef struct { int k; int l; logic [31:0] d; } em_t;
  em_t q[$];
  int hlen;
  logic [31:0] hbits, dcnt;
  bit pend;
  int checks = 0, errors = 0, cyc = 0;
  int saw_hist_full = 0, saw_ovf = 0;

  function automatic string tag_of(int k);
    case (k)
      0: return "R2";
      1: return "R4";
      2: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic push(int k, int l, logic [31:0] d);
    em_t e;
    e.k = k; e.l = l; e.d = d;
    q.push_back(e);
  endtask

  task automatic model(bit br, bit tk, bit ind, bit exc, logic [31:0] a, bit pop);
    int free, nl, need;
    bit jump, ev, fl;
    logic [31:0] nb;
    free = DEPTH - q.size();
    jump = ind | exc;
    ev   = br | jump;
    nl   = hlen + int'(br);
    nb   = hbits | ((br && tk) ? (32'd1 << hlen) : 32'd0);
    fl   = (nl == HW) || (jump && nl != 0);
    need = int'(fl) + int'(jump);
    if (pop) void'(q.pop_front());
    if (pend) begin
      hlen = 0; hbits = '0;
      if (free > 0) begin
        push(3, 0, dcnt + 32'(ev));
        pend = 0; dcnt = '0;
      end else dcnt = dcnt + 32'(ev);
    end else if (need > free) begin
      pend = 1; dcnt = 32'd1; hlen = 0; hbits = '0;
    end else begin
      if (fl) begin
        push(0, nl, nb);
        if (nl == HW) saw_hist_full++;
        hlen = 0; hbits = '0;
      end else begin
        hlen = nl; hbits = nb;
      end
      if (jump) push(exc ? 2 : 1, 0, a);
    end
  endtask

  task automatic compare(string vtag);
    bit ev = (q.size() > 0);
    checks++;
    if (msg_valid !== ev) begin
      errors++;
      $display("FAIL %s valid actual=%0b expected=%0b (cycle %0d)", vtag, msg_valid, ev, cyc);
    end else if (ev) begin
      if (q[0].k == 3) saw_ovf++;
      if (int'(msg_type) != q[0].k || int'(msg_len) != q[0].l || msg_payload !== q[0].d) begin
        errors++;
        $display("FAIL %s R8 head actual=%0d/%0d/%h expected=%0d/%0d/%h (cycle %0d)",
                 tag_of(q[0].k), msg_type, msg_len, msg_payload, q[0].k, q[0].l, q[0].d, cyc);
      end
    end
  endtask

  task automatic step(bit br, bit tk, bit ind, bit exc, logic [31:0] a, bit rdy, string vtag);
    bit pop;
    @(negedge clk);
    cyc++;
    compare(vtag);
    br_valid = br; br_taken = tk; ind_valid = ind; exc_valid = exc;
    ev_addr = a; msg_ready = rdy;
    pop = (q.size() > 0) && rdy;
    model(br, tk, ind, exc, a, pop);
  endtask

  task automatic check(string tag, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] pat;
    int ovf_before;
    void'($urandom(32'd20240611));
    hlen = 0; hbits = '0; pend = 0; dcnt = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: empty after reset
    check("R1 reset valid", msg_valid == 1'b0, int'(msg_valid), 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, '0, 1, "R1");

    // R2: sixteen outcomes fill the history
    pat = 16'hA5C3;
    for (int i = 0; i < HW; i++) step(1, pat[i], 0, 0, '0, 1, "R2");
    step(0, 0, 0, 0, '0, 1, "R2");
    check("R2 full history seen", saw_hist_full == 1, saw_hist_full, 1);

    // R3: idle cycles do not disturb a partial history
    step(1, 1, 0, 0, '0, 1, "R3");
    step(1, 0, 0, 0, '0, 1, "R3");
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, '0, 1, "R3");
    check("R3 partial history kept", hlen == 2, hlen, 2);
    // R4: indirect flushes the two-bit history then the target
    step(0, 0, 1, 0, 32'h0000_1234, 1, "R4");
    step(0, 0, 0, 0, '0, 0, "R4");
    check("R4 flush+target queued", q.size() == 2, q.size(), 2);
    check("R4 flush first", q[0].k == 0 && q[0].l == 2 && q[0].d == 32'h1, q[0].l, 2);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, '0, 1, "R4");

    // R6: branch in the same cycle as exception; R5: both strobes
    step(1, 1, 0, 0, '0, 1, "R6");
    step(1, 1, 0, 1, 32'hDEAD_0004, 0, "R6");
    check("R6 history then target", q.size() == 2 && q[0].l == 2 && q[0].d == 32'h3 && q[1].k == 2,
          q.size(), 2);
    step(0, 0, 1, 1, 32'h0BAD_0008, 0, "R5");
    check("R5 only exception queued", q.size() == 3 && q[2].k == 2, q.size(), 3);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, '0, 1, "R5");
    // R6: sixteenth outcome coincides with an indirect jump
    for (int i = 0; i < HW - 1; i++) step(1, 0, 0, 0, '0, 1, "R6");
    step(1, 1, 1, 0, 32'h0000_0040, 0, "R6");
    check("R6 full+jump one history", q.size() == 2 && q[0].l == HW && q[0].d == 32'h8000,
          q[0].l, HW);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, '0, 1, "R6");

    // R7: stall the sink and overfill
    ovf_before = saw_ovf;
    for (int i = 0; i < 10; i++) step(0, 0, 1, 0, 32'h100 + 32'(i), 0, "R7");
    check("R7 pending overflow", pend == 1, int'(pend), 1);
    step(0, 0, 1, 0, 32'h200, 1, "R7");
    step(1, 1, 0, 0, '0, 1, "R7");
    check("R7 overflow count", q.size() > 0 && q[q.size()-1].k == 3 && q[q.size()-1].d == 32'd4,
          int'(q[q.size()-1].d), 4);
    for (int i = 0; i < 12; i++) step(0, 0, 0, 0, '0, 1, "R7");
    check("R7 overflow seen", saw_ovf > ovf_before, saw_ovf, ovf_before + 1);

    // random mix with varying sink readiness (R8 ordering)
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(99);
      int rr = (i / 500) % 3;
      bit rdy = (rr == 0) ? 1'b1 : (rr == 1) ? ($urandom_range(1) == 1) : ($urandom_range(9) == 0);
      step(r < 45, $urandom_range(1) == 1, (r >= 45 && r < 55), (r >= 53 && r < 58),
           $urandom(), rdy, "R8");
    end
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0, '0, 1, "R8");
    check("R8 drained", msg_valid == 1'b0 && q.size() == 0, int'(msg_valid), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule